// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a synchronous request/acknowledge port and an external asynchronous static RAM. The RAM has a 20-bit address, a pair of chip enables (one active low, one active high), an active-low write strobe, an active-low output enable and an 8-bit bidirectional data bus. A single read or write is accepted per handshake. The controller then holds the address and both enables for a whole memory cycle and shapes the strobes to the RAM's minimum pulse, setup and cycle times. Every one of those times is set as a picosecond parameter and converted to clock cycles by rounding up.

Reads assert output enable for the full read cycle and capture the bus on the last clock. The byte is returned with a one-cycle valid pulse. Writes drive the bus only while the write strobe is low and output enable is high, so the RAM and the controller never drive the bus together. A write that follows a read waits out the RAM's bus-release time first.

Top module: `asram_ctl`

## Requirements
- R1: After reset both enables are inactive (`sram_ce_n`=1, `sram_ce`=0), `sram_we_n`=1, `sram_oe_n`=1, `req_ready`=1 and `rsp_valid`=0.
- R2: The two chip enables always show the same selection: `sram_ce_n` is the inverse of `sram_ce` in every cycle.
- R3: A read keeps the RAM selected with `sram_oe_n` low and `sram_we_n` high for exactly ceil(T_RC/T_CLK) cycles (9 at defaults). The bus is sampled on the last of those clocks and returned on `rsp_rdata` with `rsp_valid` high for one cycle.
- R4: A write pulls `sram_we_n` low from its first selected cycle for exactly the largest of ceil(T_PWE/T_CLK), ceil(T_SD/T_CLK) and ceil(T_AW/T_CLK) cycles (7 at defaults). `sram_oe_n` stays high throughout, and the write data is held on the bus for that whole pulse.
- R5: A write keeps the RAM selected for max(ceil(T_WC/T_CLK), pulse) cycles (9 at defaults). In every operation `sram_addr` equals the accepted address and stays constant while selected.
- R6: `req_ready` is high only while no operation is in progress. Requests offered while busy have no effect. Back-to-back reads, writes, or a write followed by a read leave the RAM deselected for exactly one cycle between operations.
- R7: After a read, `sram_we_n` does not fall until `sram_oe_n` has been high for ceil(T_HZ/T_CLK) cycles (4 at defaults). A write offered at once after a read therefore sees exactly that many deselected cycles.
- R8: `sram_we_n` and `sram_oe_n` are never low in the same cycle.
- R9: `rsp_valid` pulses once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 20 | RAM address |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The hardest case to reach is a write that arrives while a read is still running, because the turnaround window only matters when the write is accepted at the earliest legal edge. The bench issues the write straight after the read and measures the deselected gap and the output-enable-high span at the ports. Its RAM model returns junk until the access time has run out, so a read that samples one cycle early shows up as a data error. A full sweep of all 256 byte values over aliasing-free addresses, each written and then read back, checks the strobe widths on every operation.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WPULS = 2'd2,
        ST_WREC  = 2'd3
    } ctl_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_ctl_turn.sv
module asram_ctl_turn #(
    parameter int unsigned TURN_CLK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_end,
    output logic turn_ok
);
    localparam int unsigned TW = $clog2(TURN_CLK + 1);

    logic [TW-1:0] turn_d, turn_q;

    always_comb begin
        turn_d = turn_q;
        if (read_end) begin
            turn_d = TW'(1);
        end else if (turn_q < TW'(TURN_CLK)) begin
            turn_d = turn_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) turn_q <= TW'(TURN_CLK);
        else        turn_q <= turn_d;
    end

    assign turn_ok = (turn_q >= TW'(TURN_CLK));

endmodule

// File: rtl/asram_ctl_dq.sv
module asram_ctl_dq #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] pad
);
    assign pad   = drive ? wdata : {DATA_W{1'bz}};
    assign rdata = pad;
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned T_RC_PS   = 45000,
    parameter int unsigned T_WC_PS   = 45000,
    parameter int unsigned T_PWE_PS  = 35000,
    parameter int unsigned T_SD_PS   = 25000,
    parameter int unsigned T_AW_PS   = 35000,
    parameter int unsigned T_HZ_PS   = 18000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int unsigned RD_CLK   = max2(1, ceil_div(T_RC_PS, CLK_PS));
    localparam int unsigned WP_CLK   = max2(1, max2(ceil_div(T_PWE_PS, CLK_PS),
                                              max2(ceil_div(T_SD_PS, CLK_PS),
                                                   ceil_div(T_AW_PS, CLK_PS))));
    localparam int unsigned WC_CLK   = max2(ceil_div(T_WC_PS, CLK_PS), WP_CLK);
    localparam int unsigned REC_CLK  = WC_CLK - WP_CLK;
    localparam int unsigned TURN_CLK = max2(1, ceil_div(T_HZ_PS, CLK_PS));
    localparam int unsigned CNT_W    = $clog2(max2(RD_CLK, WC_CLK) + 1);
    localparam int unsigned RD_LAST  = RD_CLK - 1;
    localparam int unsigned WP_LAST  = WP_CLK - 1;
    localparam int unsigned REC_LAST = (REC_CLK > 0) ? REC_CLK - 1 : 0;

    typedef struct packed {
        ctl_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic                sel;
        logic                we_n;
        logic                oe_n;
        logic                drv;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                rsp;
    } ctl_t;

    ctl_t              d, q;
    logic              read_end;
    logic              turn_ok;
    logic [DATA_W-1:0] dq_in;

    assign read_end  = (q.st == ST_READ) && (q.cnt == CNT_W'(RD_LAST));
    assign req_ready = (q.st == ST_IDLE) && (!req_write || turn_ok);

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    d.addr = req_addr;
                    d.sel  = 1'b1;
                    d.cnt  = '0;
                    if (req_write) begin
                        d.st    = ST_WPULS;
                        d.we_n  = 1'b0;
                        d.drv   = 1'b1;
                        d.wdata = req_wdata;
                    end else begin
                        d.st   = ST_READ;
                        d.oe_n = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (read_end) begin
                    d.rdata = dq_in;
                    d.rsp   = 1'b1;
                    d.sel   = 1'b0;
                    d.oe_n  = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WPULS: begin
                if (q.cnt == CNT_W'(WP_LAST)) begin
                    d.we_n = 1'b1;
                    d.drv  = 1'b0;
                    d.cnt  = '0;
                    if (REC_CLK == 0) begin
                        d.sel = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.st  = ST_WREC;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WREC: begin
                if (q.cnt == CNT_W'(REC_LAST)) begin
                    d.sel = 1'b0;
                    d.st  = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    asram_ctl_turn #(.TURN_CLK(TURN_CLK)) u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_end (read_end),
        .turn_ok  (turn_ok)
    );

    asram_ctl_dq #(.DATA_W(DATA_W)) u_dq (
        .drive (q.drv),
        .wdata (q.wdata),
        .rdata (dq_in),
        .pad   (sram_dq)
    );

    assign sram_addr = q.addr;
    assign sram_ce_n = ~q.sel;
    assign sram_ce   = q.sel;
    assign sram_we_n = q.we_n;
    assign sram_oe_n = q.oe_n;
    assign rsp_valid = q.rsp;
    assign rsp_rdata = q.rdata;

    // Checker state: strobe low-run and output-enable high-run counters.
    logic [CNT_W:0] we_low_q;
    logic [CNT_W:0] oe_high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_q  <= '0;
            oe_high_q <= (CNT_W+1)'(TURN_CLK);
        end else begin
            we_low_q  <= sram_we_n ? '0 : we_low_q + 1'b1;
            if (!sram_oe_n)
                oe_high_q <= '0;
            else if (oe_high_q < (CNT_W+1)'(TURN_CLK))
                oe_high_q <= oe_high_q + 1'b1;
        end
    end

    assert_no_strobe_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.drv |-> (!sram_we_n && sram_oe_n && sram_ce));

    assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_q == (CNT_W+1)'(WP_CLK)));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (oe_high_q >= (CNT_W+1)'(TURN_CLK)));

    assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sram_ce);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce && $past(sram_ce)) |-> $stable(sram_addr));

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/asram_ctl_bench.sv
module asram_ctl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PS = 5000;
    localparam int RD  = (45000 + CLK_PS - 1) / CLK_PS;
    localparam int WP  = (35000 + CLK_PS - 1) / CLK_PS;
    localparam int WC  = (45000 + CLK_PS - 1) / CLK_PS;
    localparam int DS  = (25000 + CLK_PS - 1) / CLK_PS;
    localparam int TRN = (18000 + CLK_PS - 1) / CLK_PS;
    localparam int ACC = RD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [19:0] sram_addr;
    logic        sram_ce_n, sram_ce, sram_we_n, sram_oe_n;
    wire  [7:0]  sram_dq;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    asram_ctl u_asram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_ce(sram_ce), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    logic [7:0] mem [1024];
    int         acc = 0, stab = 0;
    logic [7:0] lat_d = '0;
    logic [9:0] lat_a = '0;
    logic       prev_wr = 1'b0;
    wire rd_act = !sram_ce_n && sram_ce && sram_we_n && !sram_oe_n;
    wire wr_act = !sram_ce_n && sram_ce && !sram_we_n;

    assign sram_dq = rd_act ? ((acc >= ACC - 1) ? mem[sram_addr[9:0]] : 8'hEE) : 8'hzz;

    always @(posedge clk) begin
        acc <= rd_act ? acc + 1 : 0;
        prev_wr <= wr_act;
        if (wr_act) begin
            lat_d <= sram_dq;
            lat_a <= sram_addr[9:0];
            stab  <= (prev_wr && sram_dq == lat_d) ? stab + 1 : 1;
        end
        if (prev_wr && !wr_act) begin
            mem[lat_a] <= lat_d;
            chk(stab >= DS, "R4 data stable before write end", stab, DS);
        end
    end

    // ---------------- operation records ----------------
    logic       op_wr  [2048];
    logic [19:0] op_addr [2048];
    logic [7:0] op_exp [2048];
    logic [7:0] shadow [1024];
    int n_ops = 0, n_reads = 0;

    // ---------------- port monitor ----------------
    int we_run = 0, oe_run = 0, sel_run = 0, gap = 0, last_gap = 0;
    int since_oe = 1000, cur = 0, mon_ptr = 0, rsp_cnt = 0;
    int v_overlap = 0, v_pair = 0, v_addr = 0;
    bit saw_we = 0, prev_sel = 0, prev_we = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_we_n && !sram_oe_n) v_overlap++;
            if (sram_ce_n == sram_ce) v_pair++;
            if (!sram_we_n) we_run++;
            else begin
                if (we_run != 0) chk(we_run == WP, "R4 write pulse width", we_run, WP);
                we_run = 0;
            end
            if (!sram_oe_n) oe_run++;
            else begin
                if (oe_run != 0) chk(oe_run == RD, "R3 read strobe width", oe_run, RD);
                oe_run = 0;
            end
            if (prev_we && !sram_we_n)
                chk(since_oe >= TRN, "R7 turnaround before write", since_oe, TRN);
            since_oe = sram_oe_n ? since_oe + 1 : 0;
            prev_we = sram_we_n;
            if (sram_ce) begin
                if (!prev_sel) begin
                    last_gap = gap;
                    cur = mon_ptr;
                    mon_ptr++;
                    chk(sram_addr == op_addr[cur], "R5 address of operation", int'(sram_addr), int'(op_addr[cur]));
                end
                if (sram_addr != op_addr[cur]) v_addr++;
                if (!sram_we_n) saw_we = 1;
                sel_run++;
            end else begin
                if (prev_sel) begin
                    chk(saw_we == op_wr[cur], "R6 operation kind", int'(saw_we), int'(op_wr[cur]));
                    chk(sel_run == (saw_we ? WC : RD), "R5 selected cycles", sel_run, saw_we ? WC : RD);
                    gap = 0;
                end
                gap++;
                sel_run = 0;
                saw_we = 0;
            end
            prev_sel = sram_ce;
            if (rsp_valid) begin
                rsp_cnt++;
                chk(!op_wr[cur], "R9 response only for reads", int'(op_wr[cur]), 0);
                chk(rsp_rdata == op_exp[cur], "R3 read data", int'(rsp_rdata), int'(op_exp[cur]));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] dat);
        op_wr[n_ops]   = wr;
        op_addr[n_ops] = a;
        if (wr) shadow[a[9:0]] = dat;
        op_exp[n_ops]  = wr ? dat : shadow[a[9:0]];
        n_ops++;
        if (!wr) n_reads++;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wait_idle();
        #1;
        while (!(req_ready && sram_ce_n && !rsp_valid)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(sram_ce_n == 1'b1, "R1 ce_n at reset", int'(sram_ce_n), 1);
        chk(sram_ce == 1'b0, "R1 ce at reset", int'(sram_ce), 0);
        chk(sram_we_n == 1'b1, "R1 we_n at reset", int'(sram_we_n), 1);
        chk(sram_oe_n == 1'b1, "R1 oe_n at reset", int'(sram_oe_n), 1);
        chk(req_ready == 1'b1, "R1 ready at reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp at reset", int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep all byte values over aliasing-free addresses
        for (int i = 0; i < 256; i++)
            issue(1'b1, 20'((i * 4099) & 20'hFFFFF), 8'(i) ^ 8'h3C);
        for (int i = 0; i < 256; i++)
            issue(1'b0, 20'((i * 4099) & 20'hFFFFF), 8'h00);
        wait_idle();

        // R6: back-to-back read then read
        issue(1'b0, 20'h00010, 8'h00);
        issue(1'b0, 20'h80021, 8'h00);
        wait_idle();
        chk(last_gap == 1, "R6 read-read gap", last_gap, 1);
        // R6: write then read
        issue(1'b1, 20'hFFFFF, 8'hA7);
        issue(1'b0, 20'hFFFFF, 8'h00);
        wait_idle();
        chk(last_gap == 1, "R6 write-read gap", last_gap, 1);
        // R6: write then write
        issue(1'b1, 20'h40300, 8'h11);
        issue(1'b1, 20'h40301, 8'h22);
        wait_idle();
        chk(last_gap == 1, "R6 write-write gap", last_gap, 1);
        // R7: read then write
        issue(1'b0, 20'h40300, 8'h00);
        issue(1'b1, 20'h40302, 8'h5E);
        wait_idle();
        chk(last_gap == TRN, "R7 read-write gap", last_gap, TRN);
        issue(1'b0, 20'h40302, 8'h00);
        wait_idle();

        // R6: request offered while a read is in progress is ignored
        issue(1'b0, 20'h00123, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00124; req_wdata = 8'hC3;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0; req_write = 1'b0;
        wait_idle();
        issue(1'b0, 20'h00124, 8'h00);
        wait_idle();

        chk(v_overlap == 0, "R8 strobe overlap cycles", v_overlap, 0);
        chk(v_pair == 0, "R2 enable pair mismatches", v_pair, 0);
        chk(v_addr == 0, "R5 address changes while selected", v_addr, 0);
        chk(rsp_cnt == n_reads, "R9 response count", rsp_cnt, n_reads);
        chk(mon_ptr == n_ops, "R6 operations on memory bus", mon_ptr, n_ops);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule